// File: doc/BRIEF.md
# I2C Bus Error Detector

This block watches the two wires of an I2C bus and reports a bus error when a START or STOP condition turns up anywhere other than a byte-plus-acknowledge boundary. It brings both wires into the local clock domain through synchronizers, recognises START and STOP conditions, and counts completed SCL pulses modulo 9 from the most recent START. A START or STOP is well placed only when that count is zero.

Errors are only of interest while this device takes part in the transfer. That means it is either driving the bus as master or has been addressed as a slave. While the slave is still receiving an address, nothing is flagged. A detected error sets a sticky flag, which software clears with a write-one-to-clear pulse. An interrupt line follows the flag when the error interrupt enable is set.

Independently of errors, every START seen while the device is not master produces a one-cycle pulse. The pulse tells the slave logic to go back to address recognition, and it fires for misplaced STARTs as well as correct ones. All pins are plain control and status signals. There is no streaming data path.

Top module: `i2c_bus_err_det`

## Requirements
- R1: A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. An SDA change while SCL is low is data and detects nothing.
- R2: SCL and SDA pass through two synchronizer flops. A pin change that completes a misplaced condition shows on `err_flag` after the third rising `clk` edge that follows it, and not before.
- R3: Every START, whether placed correctly or not, makes the count read -1 mod 9, which is 8. Each SCL falling edge then advances the count modulo 9. The falling edge that ends the START itself brings it to 0, and so does the fall after each 9th bit.
- R4: While `is_master` or `is_addr_slave` is 1 and `in_addr_phase` is 0, a START or STOP detected with a nonzero pulse count sets `err_flag`. With a zero count, nothing is flagged.
- R5: Nothing is flagged while both `is_master` and `is_addr_slave` are 0, or while `in_addr_phase` is 1.
- R6: `err_flag` holds until a one-cycle `err_clr`. If an error is detected in the same cycle as `err_clr`, the error wins and the flag stays 1.
- R7: `err_irq` is high exactly when `err_flag` and `err_irq_en` are both 1.
- R8: Every START detected while `is_master` is 0 produces a one-cycle `addr_restart` pulse, whether the START was placed correctly or not. No pulse is produced while `is_master` is 1.
- R9: After reset, `err_flag`, `err_irq` and `addr_restart` are 0. The pulse count is 0 and both synchronized lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line, asynchronous |
| sda_in | input | 1 | SDA line, asynchronous |
| is_master | input | 1 | Device currently owns the bus as master |
| is_addr_slave | input | 1 | Device has been addressed as a slave |
| in_addr_phase | input | 1 | Slave is still receiving the address |
| err_irq_en | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| err_flag | output | 1 | Sticky bus error flag |
| err_irq | output | 1 | Error interrupt |
| addr_restart | output | 1 | Pulse: slave returns to address recognition |

## Verification
The assertions assume three things about the inputs:
- The role inputs change only between bus conditions.
- `err_clr` is a single-cycle pulse.
- SDA and SCL never move in the same synchronized sample.

Under these assumptions, START and STOP cannot coincide, and two STARTs cannot occur on back-to-back cycles. The stimulus keeps within these limits in two ways. It drives the bus one wire at a time, holding each level for several clocks. It also changes the role and enable inputs only while the bus rests between conditions.

// File: rtl/i2c_bed_pkg.sv
package i2c_bed_pkg;
  // Decoded per-cycle bus events from the synchronized lines
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_fall;
  } bus_evt_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/i2c_bed_sync.sv
module i2c_bed_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= {WIDTH{RST_VAL}};
        end else begin
          if (s == 0) stage[s] <= d;
          else        stage[s] <= stage[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_bed_cond_det.sv
module i2c_bed_cond_det
  import i2c_bed_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_s & scl_q;

  always_comb begin
    evt.start    = scl_held_high &  sda_q & ~sda_s;
    evt.stop     = scl_held_high & ~sda_q &  sda_s;
    evt.scl_fall = scl_q & ~scl_s;
  end
endmodule

// File: rtl/i2c_bed_pulse_cnt.sv
module i2c_bed_pulse_cnt #(
  parameter int unsigned MOD   = 9,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_boundary
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (reload) begin
      // START counts as -1 so that its own SCL fall lands on 0
      cnt <= LAST;
    end else if (step) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign at_boundary = (cnt == '0);
endmodule

// File: rtl/i2c_bus_err_det.sv
module i2c_bus_err_det
  import i2c_bed_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic is_master,
  input  logic is_addr_slave,
  input  logic in_addr_phase,
  input  logic err_irq_en,
  input  logic err_clr,
  output logic err_flag,
  output logic err_irq,
  output logic addr_restart
);
  localparam int unsigned CNT_W = cnt_width(BYTE_PULSES);

  logic [1:0]       lines_s;
  bus_evt_t         evt;
  logic [CNT_W-1:0] pulse_cnt;
  logic             on_boundary;
  logic             involved;
  logic             misplaced;
  logic             err_set;

  i2c_bed_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (lines_s)
  );

  i2c_bed_cond_det u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_s(lines_s[1]),
    .sda_s(lines_s[0]),
    .evt  (evt)
  );

  i2c_bed_pulse_cnt #(
    .MOD  (BYTE_PULSES),
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (evt.start),
    .step       (evt.scl_fall),
    .cnt        (pulse_cnt),
    .at_boundary(on_boundary)
  );

  assign involved  = (is_master | is_addr_slave) & ~in_addr_phase;
  assign misplaced = (evt.start | evt.stop) & ~on_boundary;
  assign err_set   = misplaced & involved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag     <= 1'b0;
      addr_restart <= 1'b0;
    end else begin
      if (err_set)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
      addr_restart <= evt.start & ~is_master;
    end
  end

  assign err_irq = err_flag & err_irq_en;
endmodule

// File: rtl/i2c_bed_checker.sv
module i2c_bed_checker #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned BYTE_PULSES = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             stop_det,
  input logic [CNT_W-1:0] cnt,
  input logic             is_master,
  input logic             is_addr_slave,
  input logic             in_addr_phase,
  input logic             err_irq_en,
  input logic             err_clr,
  input logic             err_flag,
  input logic             err_irq,
  input logic             addr_restart
);
  a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(BYTE_PULSES));

  a_r3_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> cnt == CNT_W'(BYTE_PULSES - 1));

  a_r4_boundary_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det || stop_det) && cnt == '0 && !err_flag) |=> !err_flag);

  a_r5_no_role: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !is_master && !is_addr_slave) |=> !err_flag);

  a_r5_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && in_addr_phase) |=> !err_flag);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && err_clr && !start_det && !stop_det) |=> !err_flag);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !err_irq_en |-> !err_irq);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    addr_restart |=> !addr_restart);

  a_r8_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !is_master) |=> addr_restart);
endmodule

bind i2c_bus_err_det i2c_bed_checker #(
  .CNT_W      (CNT_W),
  .BYTE_PULSES(BYTE_PULSES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_det    (evt.start),
  .stop_det     (evt.stop),
  .cnt          (pulse_cnt),
  .is_master    (is_master),
  .is_addr_slave(is_addr_slave),
  .in_addr_phase(in_addr_phase),
  .err_irq_en   (err_irq_en),
  .err_clr      (err_clr),
  .err_flag     (err_flag),
  .err_irq      (err_irq),
  .addr_restart (addr_restart)
);

// File: tb/tb_i2c_bus_err_det.sv
`timescale 1ns/1ps
module tb_i2c_bus_err_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_pin = 1'b1, sda_pin = 1'b1;
  logic is_master = 1'b0, is_addr_slave = 1'b0, in_addr_phase = 1'b0;
  logic err_irq_en = 1'b0, err_clr = 1'b0;
  logic err_flag, err_irq, addr_restart;

  int n_checks = 0;
  int n_fail = 0;
  int restarts = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_err_det dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_pin), .sda_in(sda_pin),
    .is_master(is_master), .is_addr_slave(is_addr_slave),
    .in_addr_phase(in_addr_phase), .err_irq_en(err_irq_en),
    .err_clr(err_clr), .err_flag(err_flag), .err_irq(err_irq),
    .addr_restart(addr_restart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: pin history queues model the sampling delay
  bit q_scl[$];
  bit q_sda[$];
  int pulses = 0;
  bit m_flag = 1'b0, m_restart = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_scl = '{1, 1, 1};
      q_sda = '{1, 1, 1};
      pulses = 0;
      m_flag = 0;
      m_restart = 0;
    end else begin
      bit ps, cs, pd, cd, st, sp, fl, bad;
      ps = q_scl[0]; cs = q_scl[1]; pd = q_sda[0]; cd = q_sda[1];
      st = ps && cs && pd && !cd;
      sp = ps && cs && !pd && cd;
      fl = ps && !cs;
      bad = (st || sp) && ((((pulses % 9) + 9) % 9) != 0);
      if (bad && (is_master || is_addr_slave) && !in_addr_phase) m_flag = 1;
      else if (err_clr) m_flag = 0;
      m_restart = st && !is_master;
      if (st) pulses = -1;
      else if (fl) pulses++;
      void'(q_scl.pop_front()); q_scl.push_back(scl_pin);
      void'(q_sda.pop_front()); q_sda.push_back(sda_pin);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(err_flag == m_flag, "R4 model err_flag", err_flag, m_flag);
      check(err_irq == (m_flag && err_irq_en), "R7 model err_irq", err_irq, m_flag && err_irq_en);
      check(addr_restart == m_restart, "R8 model addr_restart", addr_restart, m_restart);
      if (addr_restart) restarts++;
    end
  end

  task automatic set_pins(input bit s, input bit d);
    scl_pin = s; sda_pin = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_pin) set_pins(0, 1);
    set_pins(1, 1);
    set_pins(1, 0);
    set_pins(0, 0);
  endtask

  task automatic bus_bit(input bit b);
    set_pins(0, b);
    set_pins(1, b);
    set_pins(0, b);
  endtask

  task automatic bus_bits(input int n, input int pat);
    for (int i = 0; i < n; i++) bus_bit(pat[i % 32]);
  endtask

  task automatic bus_stop();
    set_pins(0, 0);
    set_pins(1, 0);
    set_pins(1, 1);
  endtask

  task automatic clear_flag();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(err_flag == 0, "R9 reset err_flag", err_flag, 0);
    check(err_irq == 0, "R9 reset err_irq", err_irq, 0);
    check(addr_restart == 0, "R9 reset addr_restart", addr_restart, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Correct frame as master, data toggling while SCL low
    is_master = 1; err_irq_en = 1;
    bus_start(); bus_bits(9, 32'h15A); bus_stop();
    check(err_flag == 0, "R1 R4 clean frame", err_flag, 0);

    // Repeated start on boundary, two more bytes
    bus_start(); bus_bits(9, 32'h0F3); bus_start(); bus_bits(18, 32'h2C4D1); bus_stop();
    check(err_flag == 0, "R3 boundary repeated start", err_flag, 0);

    // Misplaced STOP after 5 bits, with latency check
    bus_start(); bus_bits(5, 32'h13);
    set_pins(0, 0); set_pins(1, 0);
    sda_pin = 1'b1;
    @(negedge clk); check(err_flag == 0, "R2 no flag after 1 edge", err_flag, 0);
    @(negedge clk); check(err_flag == 0, "R2 no flag after 2 edges", err_flag, 0);
    @(negedge clk); check(err_flag == 1, "R2 flag after 3 edges", err_flag, 1);
    repeat (4) @(negedge clk);
    check(err_flag == 1, "R4 misplaced stop", err_flag, 1);
    check(err_irq == 1, "R7 irq with enable", err_irq, 1);
    err_irq_en = 0; @(negedge clk);
    check(err_irq == 0, "R7 irq masked", err_irq, 0);
    check(err_flag == 1, "R6 flag sticky", err_flag, 1);
    clear_flag();
    check(err_flag == 0, "R6 cleared", err_flag, 0);

    // Misplaced repeated START after 3 bits
    err_irq_en = 1;
    bus_start(); bus_bits(3, 32'h5); bus_start(); bus_bits(9, 32'h1); bus_stop();
    check(err_flag == 1, "R4 misplaced start", err_flag, 1);
    check(restarts == 0, "R8 no pulse as master", restarts, 0);
    clear_flag();

    // Not involved: misplaced stop ignored, restart pulse given
    is_master = 0; restarts = 0;
    bus_start(); bus_bits(4, 32'h9); bus_stop();
    check(err_flag == 0, "R5 not involved", err_flag, 0);
    check(restarts == 1, "R8 slave start pulse", restarts, 1);

    // Addressed slave still in address phase
    is_addr_slave = 1; in_addr_phase = 1; restarts = 0;
    bus_start(); bus_bits(4, 32'h6); bus_start(); bus_bits(9, 32'h3); bus_stop();
    check(err_flag == 0, "R5 address phase", err_flag, 0);
    check(restarts == 2, "R8 pulse per start", restarts, 2);

    // Addressed slave after address: misplaced START flagged and restarts
    in_addr_phase = 0; restarts = 0;
    bus_start(); bus_bits(12, 32'hA5B); bus_start(); bus_bits(9, 32'h0); bus_stop();
    check(err_flag == 1, "R4 addressed slave error", err_flag, 1);
    check(restarts == 2, "R8 misplaced start restarts", restarts, 2);
    clear_flag();

    // SDA glitch while SCL high in mid-bit (START then STOP)
    is_addr_slave = 0; is_master = 1;
    bus_start(); bus_bits(2, 32'h0);
    set_pins(0, 1); set_pins(1, 1); set_pins(1, 0); set_pins(1, 1);
    check(err_flag == 1, "R1 mid-bit condition", err_flag, 1);
    clear_flag();

    // Error and clear in the same cycle: error wins
    bus_start(); bus_bits(2, 32'h0);
    set_pins(0, 0); set_pins(1, 0);
    sda_pin = 1'b1;
    repeat (2) @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(err_flag == 1, "R6 set beats clear", err_flag, 1);
    repeat (4) @(negedge clk);
    clear_flag();
    check(err_flag == 0, "R6 final clear", err_flag, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule